// File: doc/BRIEF.md
# KISS Frame Decoder with CRC Check

The block takes the byte stream from an asynchronous serial receiver and recovers KISS frames from it. A delimiter byte separates frames. Escape pairs are converted back to the literal bytes they stand for. The first byte of each frame is a control byte, and the block uses it to sort the frame into one of four kinds:

- a plain data frame,
- a frame protected by a 16-bit CRC,
- a mode-exit command,
- a parameter command.

Payload bytes of data frames leave the block as a valid/last stream. The last byte carries a frame-good flag, and every byte carries the port number.

For CRC-protected frames, the block checks the CRC over the control byte and the payload. The two CRC bytes are removed, and the frame-good flag on the last byte shows whether the check passed. Command frames produce no data. Instead they produce a single pulse: either an exit pulse, or a command report that carries the port, the command code and the first argument byte. Malformed frames produce an error pulse:

- a bad escape pair,
- a frame that is too long,
- a frame that is too short.

After an error the block discards input until the next delimiter.

Top module: `kiss_rx_decoder`

## Requirements
- R1: After reset every output is low, and all bytes received before the first 0xC0 delimiter are discarded without producing any output.
- R2: Consecutive delimiters with nothing between them (empty frames) produce no output of any kind.
- R3: Inside a frame, the pair 0xDB 0xDC yields the data byte 0xC0 and the pair 0xDB 0xDD yields 0xDB. This applies to the control byte, the payload and the CRC bytes alike.
- R4: A control byte whose lower nibble is 0 and which is not 0x80 marks a data frame. Its payload bytes appear on out_data in order, with out_port equal to the control byte's upper nibble. out_last is set on the final byte, and out_good is 1 on that byte and 0 on every other byte.
- R5: A control byte of 0x80 marks a CRC frame. The CRC is computed with the reflected polynomial 0x8408, starting from an all-zero register, processed LSB first over the control byte and the payload, and sent low byte first. The two CRC bytes are not forwarded, out_port is 0, and out_good on the last byte is 1 when the check matches.
- R6: A CRC frame whose check fails still delivers its payload, but out_good is 0 on its last byte.
- R7: A control byte of 0xFF gives exactly one exit_pulse at the closing delimiter and no data output. Any bytes that follow the control byte in that frame are ignored.
- R8: Any other control byte whose lower nibble is non-zero gives one cmd_valid at the closing delimiter, with cmd_port equal to the upper nibble, cmd_code equal to the lower nibble, and cmd_arg equal to the first following byte (or 0 if there is none). No data output is produced.
- R9: An escape byte followed by anything other than 0xDC or 0xDD raises err_pulse. If the offending byte is 0xC0, it opens a new frame. Otherwise input is discarded up to the next 0xC0. Payload still held inside the block is dropped, and no out_last is given for that frame.
- R10: A frame whose decoded length (control byte included) would exceed MAX_LEN raises err_pulse when the first excess byte arrives, and the rest of the frame is discarded.
- R11: At the closing delimiter, err_pulse is raised instead of data when a data frame has no payload byte, or when a CRC frame has fewer than three bytes after its control byte.
- R12: At most one of out_valid, exit_pulse, cmd_valid and err_pulse is high in any cycle. Two adjacent data bytes of a frame carry the same out_port.
- R13: Every output event appears exactly two clock cycles after the input byte that causes it is sampled. A data frame holds back one payload byte and a CRC frame holds back three, so that out_last can be placed on the final payload byte.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | A received byte is present on in_byte |
| in_byte | input | 8 | Received serial byte |
| out_valid | output | 1 | out_data carries a payload byte |
| out_data | output | 8 | Decoded payload byte |
| out_last | output | 1 | Final payload byte of the frame |
| out_good | output | 1 | Frame accepted; meaningful together with out_last |
| out_port | output | 4 | Port number of the frame being delivered |
| exit_pulse | output | 1 | Mode-exit command received |
| cmd_valid | output | 1 | Parameter command received |
| cmd_port | output | 4 | Port of the parameter command |
| cmd_code | output | 4 | Command code (lower nibble of the control byte) |
| cmd_arg | output | 8 | First argument byte of the command, 0 if none |
| err_pulse | output | 1 | Frame aborted: bad escape, overlong or too short |

## Verification
The stimulus places 0xC0 and 0xDB values in the payload, the control byte and the generated CRC bytes. A decoder that mishandles the escape pairs would then emit raw escape bytes, or split frames at the wrong place. CRC frames are sent both intact and with one CRC bit flipped. A wrong seed, bit order or byte order would either reject the intact frames or accept the damaged ones. Trimming the hold-back depth wrongly would forward CRC bytes as payload or lose the final byte.

Directed cases cover the following:
- junk before the first delimiter;
- runs of empty frames;
- a bad escape, including one whose second byte is a delimiter that must open the next frame;
- a frame one byte over the length limit, where the data already delivered must stop exactly at the limit;
- command frames with and without an argument;
- control-only frames that must be reported as too short.

// File: rtl/kiss_pkg.sv
package kiss_pkg;

    localparam logic [7:0] K_DELIM     = 8'hC0;
    localparam logic [7:0] K_ESC       = 8'hDB;
    localparam logic [7:0] K_ESC_DELIM = 8'hDC;
    localparam logic [7:0] K_ESC_ESC   = 8'hDD;
    localparam logic [7:0] CTRL_EXIT   = 8'hFF;
    localparam logic [7:0] CTRL_CRC    = 8'h80;

    typedef enum logic [1:0] {
        US_HUNT,
        US_BODY,
        US_ESC
    } unesc_state_e;

    typedef enum logic [2:0] {
        FK_NONE,
        FK_DATA,
        FK_CRC,
        FK_EXIT,
        FK_PARAM
    } frame_kind_e;

    // One byte of a reflected CRC, LSB first.
    function automatic logic [15:0] crc_step(input logic [15:0] c,
                                             input logic [7:0]  b,
                                             input logic [15:0] poly);
        logic [15:0] r;
        r = c ^ {8'h00, b};
        for (int i = 0; i < 8; i++) begin
            r = r[0] ? ((r >> 1) ^ poly) : (r >> 1);
        end
        return r;
    endfunction

endpackage

// File: rtl/kiss_unescape.sv
module kiss_unescape
    import kiss_pkg::*;
#(
    parameter int MAX_LEN = 360
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       in_valid,
    input  logic [7:0] in_byte,
    output logic       tok_valid,
    output logic [7:0] tok_byte,
    output logic       tok_eof,
    output logic       tok_err
);
    localparam int CNT_W = $clog2(MAX_LEN + 1);

    typedef struct packed {
        unesc_state_e     st;
        logic [CNT_W-1:0] cnt;
        logic             tv;
        logic [7:0]       tb;
        logic             eof;
        logic             err;
    } unesc_t;

    unesc_t state_d, state_q;

    always_comb begin
        logic       got;
        logic [7:0] dec;
        state_d     = state_q;
        state_d.tv  = 1'b0;
        state_d.eof = 1'b0;
        state_d.err = 1'b0;
        got         = 1'b0;
        dec         = in_byte;
        if (in_valid) begin
            unique case (state_q.st)
                US_HUNT: begin
                    if (in_byte == K_DELIM) begin
                        state_d.st  = US_BODY;
                        state_d.cnt = '0;
                    end
                end
                US_BODY: begin
                    if (in_byte == K_DELIM) begin
                        state_d.eof = (state_q.cnt != '0);
                        state_d.cnt = '0;
                    end else if (in_byte == K_ESC) begin
                        state_d.st = US_ESC;
                    end else begin
                        got = 1'b1;
                    end
                end
                US_ESC: begin
                    if (in_byte == K_ESC_DELIM) begin
                        got        = 1'b1;
                        dec        = K_DELIM;
                        state_d.st = US_BODY;
                    end else if (in_byte == K_ESC_ESC) begin
                        got        = 1'b1;
                        dec        = K_ESC;
                        state_d.st = US_BODY;
                    end else if (in_byte == K_DELIM) begin
                        state_d.err = 1'b1;
                        state_d.st  = US_BODY;
                        state_d.cnt = '0;
                    end else begin
                        state_d.err = 1'b1;
                        state_d.st  = US_HUNT;
                    end
                end
                default: state_d.st = US_HUNT;
            endcase
        end
        if (got) begin
            if (state_q.cnt == CNT_W'(MAX_LEN)) begin
                state_d.err = 1'b1;
                state_d.st  = US_HUNT;
            end else begin
                state_d.tv  = 1'b1;
                state_d.tb  = dec;
                state_d.cnt = state_q.cnt + CNT_W'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q     <= '0;
            state_q.st  <= US_HUNT;
        end else begin
            state_q <= state_d;
        end
    end

    assign tok_valid = state_q.tv;
    assign tok_byte  = state_q.tb;
    assign tok_eof   = state_q.eof;
    assign tok_err   = state_q.err;

endmodule

// File: rtl/kiss_crc16.sv
module kiss_crc16
    import kiss_pkg::*;
#(
    parameter logic [15:0] POLY = 16'h8408
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        clear,
    input  logic        en,
    input  logic [7:0]  din,
    output logic [15:0] crc
);
    logic [15:0] crc_d, crc_q;

    always_comb begin
        crc_d = crc_q;
        if (clear) begin
            crc_d = '0;
        end else if (en) begin
            crc_d = crc_step(crc_q, din, POLY);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) crc_q <= '0;
        else        crc_q <= crc_d;
    end

    assign crc = crc_q;

endmodule

// File: rtl/kiss_frame_ctl.sv
module kiss_frame_ctl
    import kiss_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        tok_valid,
    input  logic [7:0]  tok_byte,
    input  logic        tok_eof,
    input  logic        tok_err,
    input  logic [15:0] crc_val,
    output logic        out_valid,
    output logic [7:0]  out_data,
    output logic        out_last,
    output logic        out_good,
    output logic [3:0]  out_port,
    output logic        exit_pulse,
    output logic        cmd_valid,
    output logic [3:0]  cmd_port,
    output logic [3:0]  cmd_code,
    output logic [7:0]  cmd_arg,
    output logic        err_pulse
);
    localparam int HOLD_N = 3;

    typedef struct packed {
        frame_kind_e            kind;
        logic [3:0]             port;
        logic [3:0]             code;
        logic [7:0]             arg;
        logic                   arg_seen;
        logic [1:0]             nb;
        logic [HOLD_N-1:0][7:0] hold;
        logic                   ov;
        logic [7:0]             od;
        logic                   ol;
        logic                   og;
        logic [3:0]             op;
        logic                   ex;
        logic                   cv;
        logic [3:0]             cp;
        logic [3:0]             cc;
        logic [7:0]             ca;
        logic                   er;
    } fctl_t;

    fctl_t state_d, state_q;

    always_comb begin
        logic [1:0] dep;
        state_d    = state_q;
        state_d.ov = 1'b0;
        state_d.ol = 1'b0;
        state_d.og = 1'b0;
        state_d.ex = 1'b0;
        state_d.cv = 1'b0;
        state_d.er = 1'b0;
        dep = (state_q.kind == FK_CRC) ? 2'd3 : 2'd1;

        if (tok_err) begin
            state_d.er       = 1'b1;
            state_d.kind     = FK_NONE;
            state_d.nb       = '0;
            state_d.arg_seen = 1'b0;
        end else if (tok_valid) begin
            unique case (state_q.kind)
                FK_NONE: begin
                    state_d.port = tok_byte[7:4];
                    state_d.code = tok_byte[3:0];
                    state_d.arg  = '0;
                    state_d.nb   = '0;
                    if (tok_byte == CTRL_EXIT) begin
                        state_d.kind = FK_EXIT;
                    end else if (tok_byte == CTRL_CRC) begin
                        state_d.kind = FK_CRC;
                        state_d.port = '0;
                    end else if (tok_byte[3:0] == 4'h0) begin
                        state_d.kind = FK_DATA;
                    end else begin
                        state_d.kind     = FK_PARAM;
                        state_d.arg_seen = 1'b0;
                    end
                end
                FK_DATA, FK_CRC: begin
                    if (state_q.nb == dep) begin
                        state_d.ov = 1'b1;
                        state_d.od = state_q.hold[0];
                        state_d.op = state_q.port;
                        for (int i = 0; i < HOLD_N - 1; i++) begin
                            state_d.hold[i] = state_q.hold[i+1];
                        end
                        state_d.hold[dep - 2'd1] = tok_byte;
                    end else begin
                        state_d.hold[state_q.nb] = tok_byte;
                        state_d.nb               = state_q.nb + 2'd1;
                    end
                end
                FK_PARAM: begin
                    if (!state_q.arg_seen) begin
                        state_d.arg      = tok_byte;
                        state_d.arg_seen = 1'b1;
                    end
                end
                default: ;
            endcase
        end else if (tok_eof) begin
            unique case (state_q.kind)
                FK_DATA, FK_CRC: begin
                    if (state_q.nb == dep) begin
                        state_d.ov = 1'b1;
                        state_d.od = state_q.hold[0];
                        state_d.ol = 1'b1;
                        state_d.op = state_q.port;
                        state_d.og = (state_q.kind == FK_DATA) || (crc_val == '0);
                    end else begin
                        state_d.er = 1'b1;
                    end
                end
                FK_EXIT:  state_d.ex = 1'b1;
                FK_PARAM: begin
                    state_d.cv = 1'b1;
                    state_d.cp = state_q.port;
                    state_d.cc = state_q.code;
                    state_d.ca = state_q.arg;
                end
                default: ;
            endcase
            state_d.kind     = FK_NONE;
            state_d.nb       = '0;
            state_d.arg_seen = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q      <= '0;
            state_q.kind <= FK_NONE;
        end else begin
            state_q <= state_d;
        end
    end

    assign out_valid  = state_q.ov;
    assign out_data   = state_q.od;
    assign out_last   = state_q.ol;
    assign out_good   = state_q.og;
    assign out_port   = state_q.op;
    assign exit_pulse = state_q.ex;
    assign cmd_valid  = state_q.cv;
    assign cmd_port   = state_q.cp;
    assign cmd_code   = state_q.cc;
    assign cmd_arg    = state_q.ca;
    assign err_pulse  = state_q.er;

endmodule

// File: rtl/kiss_rx_decoder.sv
module kiss_rx_decoder
    import kiss_pkg::*;
#(
    parameter int          MAX_LEN  = 360,
    parameter logic [15:0] CRC_POLY = 16'h8408
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       in_valid,
    input  logic [7:0] in_byte,
    output logic       out_valid,
    output logic [7:0] out_data,
    output logic       out_last,
    output logic       out_good,
    output logic [3:0] out_port,
    output logic       exit_pulse,
    output logic       cmd_valid,
    output logic [3:0] cmd_port,
    output logic [3:0] cmd_code,
    output logic [7:0] cmd_arg,
    output logic       err_pulse
);
    logic        tok_valid;
    logic [7:0]  tok_byte;
    logic        tok_eof;
    logic        tok_err;
    logic [15:0] crc_val;

    kiss_unescape #(.MAX_LEN(MAX_LEN)) u_unesc (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_byte   (in_byte),
        .tok_valid (tok_valid),
        .tok_byte  (tok_byte),
        .tok_eof   (tok_eof),
        .tok_err   (tok_err)
    );

    kiss_crc16 #(.POLY(CRC_POLY)) u_crc (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (tok_eof | tok_err),
        .en    (tok_valid),
        .din   (tok_byte),
        .crc   (crc_val)
    );

    kiss_frame_ctl u_ctl (
        .clk        (clk),
        .rst_n      (rst_n),
        .tok_valid  (tok_valid),
        .tok_byte   (tok_byte),
        .tok_eof    (tok_eof),
        .tok_err    (tok_err),
        .crc_val    (crc_val),
        .out_valid  (out_valid),
        .out_data   (out_data),
        .out_last   (out_last),
        .out_good   (out_good),
        .out_port   (out_port),
        .exit_pulse (exit_pulse),
        .cmd_valid  (cmd_valid),
        .cmd_port   (cmd_port),
        .cmd_code   (cmd_code),
        .cmd_arg    (cmd_arg),
        .err_pulse  (err_pulse)
    );

endmodule

// File: rtl/kiss_rx_decoder_chk.sv
module kiss_rx_decoder_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       in_valid,
    input logic       out_valid,
    input logic       out_last,
    input logic       out_good,
    input logic [3:0] out_port,
    input logic       exit_pulse,
    input logic       cmd_valid,
    input logic       err_pulse
);
    // R12: one event kind per cycle
    p_single_event_r12: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({out_valid, exit_pulse, cmd_valid, err_pulse}));

    // R4: good flag only on a delivered final byte
    p_good_on_last_r4: assert property (@(posedge clk) disable iff (!rst_n)
        out_good |-> (out_valid && out_last));

    // R12: adjacent bytes of one frame share the port
    p_port_steady_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_last) |=> (!out_valid || $stable(out_port)));

    // R13: every event traces back to a byte two cycles earlier
    p_two_cycle_latency_r13: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid || exit_pulse || cmd_valid || err_pulse) |-> $past(in_valid, 2));

    // R9: an abort is never directly followed by payload
    p_no_data_after_abort_r9: assert property (@(posedge clk) disable iff (!rst_n)
        err_pulse |=> !out_valid);

endmodule

bind kiss_rx_decoder kiss_rx_decoder_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .out_valid  (out_valid),
    .out_last   (out_last),
    .out_good   (out_good),
    .out_port   (out_port),
    .exit_pulse (exit_pulse),
    .cmd_valid  (cmd_valid),
    .err_pulse  (err_pulse)
);

// File: tb/tb_kiss_rx_decoder.sv
module tb_kiss_rx_decoder;
    localparam int CLK_PERIOD = 10;
    localparam int MAXL       = 40;

    logic       clk;
    logic       rst_n;
    logic       in_valid;
    logic [7:0] in_byte;
    logic       out_valid;
    logic [7:0] out_data;
    logic       out_last;
    logic       out_good;
    logic [3:0] out_port;
    logic       exit_pulse;
    logic       cmd_valid;
    logic [3:0] cmd_port;
    logic [3:0] cmd_code;
    logic [7:0] cmd_arg;
    logic       err_pulse;

    int n_checks;
    int n_errors;
    logic [31:0] exp_q[$];
    logic [31:0] got_q[$];

    kiss_rx_decoder #(.MAX_LEN(MAXL)) dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_byte(in_byte),
        .out_valid(out_valid), .out_data(out_data), .out_last(out_last),
        .out_good(out_good), .out_port(out_port), .exit_pulse(exit_pulse),
        .cmd_valid(cmd_valid), .cmd_port(cmd_port), .cmd_code(cmd_code),
        .cmd_arg(cmd_arg), .err_pulse(err_pulse)
    );

    initial clk = 1'b0;
    always #(CLK_PERIOD/2) clk = ~clk;

    // Event encoding: [31:24] kind (1 data, 2 exit, 3 command, 4 error)
    function automatic logic [31:0] ev_data(logic [7:0] b, logic [3:0] p, logic l, logic g);
        return {8'h01, b, p, 4'h0, 6'h00, l, g};
    endfunction

    always @(negedge clk) begin
        if (rst_n) begin
            if (out_valid)  got_q.push_back(ev_data(out_data, out_port, out_last, out_good));
            if (exit_pulse) got_q.push_back({8'h02, 24'h0});
            if (cmd_valid)  got_q.push_back({8'h03, cmd_arg, cmd_port, cmd_code, 8'h00});
            if (err_pulse)  got_q.push_back({8'h04, 24'h0});
        end
    end

    function automatic logic [15:0] crc_of(input logic [7:0] bytes[$]);
        logic [15:0] c;
        c = 16'h0000;
        foreach (bytes[i]) begin
            c = c ^ {8'h00, bytes[i]};
            for (int k = 0; k < 8; k++) c = c[0] ? ((c >> 1) ^ 16'h8408) : (c >> 1);
        end
        return c;
    endfunction

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            #1;
        end
    endtask

    task automatic send(input logic [7:0] b);
        in_valid = 1'b1;
        in_byte  = b;
        @(posedge clk);
        #1;
        in_valid = 1'b0;
        in_byte  = 8'h00;
    endtask

    task automatic send_esc(input logic [7:0] b);
        if (b == 8'hC0) begin
            send(8'hDB); send(8'hDC);
        end else if (b == 8'hDB) begin
            send(8'hDB); send(8'hDD);
        end else begin
            send(b);
        end
    endtask

    task automatic expect_payload(input logic [3:0] p, input logic [7:0] pay[$], input logic good);
        foreach (pay[i]) begin
            logic l;
            l = (i == pay.size() - 1);
            exp_q.push_back(ev_data(pay[i], p, l, l & good));
        end
    endtask

    task automatic data_frame(input logic [7:0] ctrl, input logic [7:0] pay[$]);
        send(8'hC0);
        send_esc(ctrl);
        foreach (pay[i]) send_esc(pay[i]);
        send(8'hC0);
        expect_payload(ctrl[7:4], pay, 1'b1);
    endtask

    task automatic crc_frame(input logic [7:0] pay[$], input logic corrupt);
        logic [7:0]  all[$];
        logic [15:0] c;
        all = pay;
        all.push_front(8'h80);
        c = crc_of(all);
        if (corrupt) c = c ^ 16'h0100;
        send(8'hC0);
        foreach (all[i]) send_esc(all[i]);
        send_esc(c[7:0]);
        send_esc(c[15:8]);
        send(8'hC0);
        expect_payload(4'h0, pay, !corrupt);
    endtask

    task automatic compare(input string req);
        idle(4);
        n_checks++;
        if (got_q.size() != exp_q.size()) begin
            n_errors++;
            $display("FAIL %s: event count %0d expected %0d", req, got_q.size(), exp_q.size());
        end
        for (int i = 0; i < got_q.size() && i < exp_q.size(); i++) begin
            n_checks++;
            if (got_q[i] !== exp_q[i]) begin
                n_errors++;
                $display("FAIL %s: event %0d got %h expected %h", req, i, got_q[i], exp_q[i]);
            end
        end
        got_q.delete();
        exp_q.delete();
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_errors++;
        $display("FAIL watchdog: run did not complete, got hang expected finish");
        finish_run();
    end

    initial begin
        logic [7:0] pay[$];
        n_checks = 0;
        n_errors = 0;
        rst_n    = 1'b0;
        in_valid = 1'b0;
        in_byte  = 8'h00;
        void'($urandom(32'h5EED1234));
        idle(3);
        rst_n = 1'b1;
        idle(1);

        // R1: reset state
        n_checks++;
        if ({out_valid, out_last, out_good, exit_pulse, cmd_valid, err_pulse} !== 6'b0) begin
            n_errors++;
            $display("FAIL R1: outputs after reset got %b expected 000000",
                     {out_valid, out_last, out_good, exit_pulse, cmd_valid, err_pulse});
        end

        // R1: junk before the first delimiter is ignored
        send(8'h00); send(8'h41); send(8'hDB); send(8'h42);
        pay = '{8'h55};
        data_frame(8'h00, pay);
        compare("R1");

        // R2: empty frames
        send(8'hC0); send(8'hC0); send(8'hC0); send(8'hC0);
        compare("R2");

        // R3: escaped payload and escaped control byte
        pay = '{8'hC0, 8'hDB, 8'h41, 8'hDB, 8'hC0};
        data_frame(8'h00, pay);
        pay = '{8'h01};
        data_frame(8'hC0, pay);
        compare("R3");

        // R4: nonzero port, multi-byte payload
        pay = '{8'h10, 8'h20, 8'h30, 8'h40};
        data_frame(8'h50, pay);
        compare("R4");

        // R5: CRC frame, intact
        pay = '{8'h11, 8'hC0, 8'h22, 8'hDB, 8'h33};
        crc_frame(pay, 1'b0);
        pay = '{8'hA5};
        crc_frame(pay, 1'b0);
        compare("R5");

        // R6: CRC frame, damaged check
        pay = '{8'h01, 8'h02, 8'h03};
        crc_frame(pay, 1'b1);
        compare("R6");

        // R7: exit command with trailing byte
        send(8'hC0); send(8'hFF); send(8'h55); send(8'hC0);
        exp_q.push_back({8'h02, 24'h0});
        compare("R7");

        // R8: parameter commands with and without argument
        send(8'hC0); send(8'h31); send(8'h07); send(8'h08); send(8'hC0);
        exp_q.push_back({8'h03, 8'h07, 4'h3, 4'h1, 8'h00});
        send(8'hC0); send(8'hA2); send(8'hC0);
        exp_q.push_back({8'h03, 8'h00, 4'hA, 4'h2, 8'h00});
        compare("R8");

        // R9: bad escape, discard to next delimiter
        send(8'hC0); send(8'h00); send(8'h11); send(8'hDB); send(8'h41);
        send(8'h22); send(8'hC0);
        exp_q.push_back({8'h04, 24'h0});
        pay = '{8'h66};
        data_frame(8'h00, pay);
        // R9: bad escape where the offending byte is a delimiter
        send(8'hC0); send(8'h00); send(8'h11); send(8'hDB); send(8'hC0);
        send(8'h00); send(8'h22); send(8'hC0);
        exp_q.push_back({8'h04, 24'h0});
        exp_q.push_back(ev_data(8'h22, 4'h0, 1'b1, 1'b1));
        compare("R9");

        // R10: overlong frame
        send(8'hC0); send(8'h00);
        for (int i = 0; i < MAXL + 5; i++) send(8'(8'h10 + i));
        send(8'hC0);
        for (int i = 0; i < MAXL - 2; i++) exp_q.push_back(ev_data(8'(8'h10 + i), 4'h0, 1'b0, 1'b0));
        exp_q.push_back({8'h04, 24'h0});
        pay = '{8'h77};
        data_frame(8'h00, pay);
        compare("R10");

        // R11: too-short frames
        send(8'hC0); send(8'h00); send(8'hC0);
        exp_q.push_back({8'h04, 24'h0});
        send(8'hC0); send(8'h80); send(8'hAA); send(8'hBB); send(8'hC0);
        exp_q.push_back({8'h04, 24'h0});
        compare("R11");

        // R4 R5 R6 R13: random mix of frames with gaps
        for (int f = 0; f < 60; f++) begin
            logic [7:0] rp[$];
            int         len;
            int         kind;
            logic [3:0] prt;
            len  = $urandom_range(1, 12);
            kind = $urandom_range(0, 2);
            rp.delete();
            for (int i = 0; i < len; i++) begin
                int sel;
                sel = $urandom_range(0, 3);
                if (sel == 0)      rp.push_back(8'hC0);
                else if (sel == 1) rp.push_back(8'hDB);
                else               rp.push_back(8'($urandom_range(0, 255)));
            end
            prt = 4'($urandom_range(0, 15));
            if (prt == 4'h8) prt = 4'h9;
            if (kind == 0)      data_frame({prt, 4'h0}, rp);
            else if (kind == 1) crc_frame(rp, 1'b0);
            else                crc_frame(rp, 1'b1);
            idle($urandom_range(0, 3));
            if ($urandom_range(0, 4) == 0) send(8'hC0);
        end
        compare("R4/R5/R6 random");

        finish_run();
    end

endmodule